// File: doc/BRIEF.md
# CAS-Latency Read Data Pipeline

This block sets the read-data timing of a synchronous DRAM data port. An internal column source hands it one 16-bit word per clock while a read burst runs. The block delays those words by the CAS latency that was programmed when the READ was registered. It then drives them onto the data pins, with a separate output enable for each byte lane. Per-byte masks act on reads two clocks after they are sampled. On writes they act in the same cycle, as per-byte write enables toward the array.

A READ may arrive while an earlier read burst is still running. The new burst cuts the old one short and continues the data stream with no idle slot. A WRITE stops any read at once and releases the pins. A READ ends any write burst that is still running. If the latency input is changed while read words are still owed, the block raises an error flag. It keeps using the latency it latched with the READ.

Top module: `casrd_pipe`

## Requirements
- R1: A READ registered at edge n, with latency code `casLat` m (1, 2 or 3), drives its first word right after edge n+m-1, so the word is valid at edge n+m. Word k of the burst is the `srcData` value sampled at edge n+k.
- R2: A burst delivers one word per clock. The length code `burstSel` selects 1, 2, 4 or 8 words (codes 0, 1, 2, 3).
- R3: `dqm` bit 0 masks bits 7:0 and `dqm` bit 1 masks bits 15:8. A mask bit sampled high at edge e turns off the enable of its lane for the output slot that follows edge e+1.
- R4: During a write burst, `wrByteEn` is the inverse of `dqm` in the same cycle, with no register in the path. The write burst lasts as many cycles as `burstSel` gives.
- R5: A READ registered while an earlier read burst is running ends that burst. The new burst's first word comes straight after the last word of the old burst that was sent, with no gap.
- R6: A WRITE registered at edge w cancels every read word not yet driven. `dqOe` is zero after edge w. READ and WRITE are never asserted together.
- R7: When a lane is not enabled, its `dqOe` bit is low and its bits of `dqOut` are zero. An idle block drives nothing.
- R8: If `casLat` differs from the latched latency while read words are still owed, `latErr` is high after the next edge. The burst in flight keeps its latched latency.
- R9: After reset, `dqOe`, `dqOut` and `latErr` are zero. Both mask stages start as masked, so no lane is enabled before two edges have passed.
- R10: A READ ends any running write burst: `wrByteEn` is zero in the cycle the READ is presented and stays zero after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rdCmd | input | 1 | READ command strobe |
| wrCmd | input | 1 | WRITE command strobe |
| casLat | input | 2 | Latency code, 1 to 3 clocks |
| burstSel | input | 2 | Burst length code: 1, 2, 4 or 8 words |
| dqm | input | 2 | Byte masks; bit 0 for the low byte, bit 1 for the high byte |
| srcData | input | 16 | Column word from the array, one per clock |
| dqOut | output | 16 | Data driven toward the pins |
| dqOe | output | 2 | Output enable for each byte lane |
| wrByteEn | output | 2 | Write enable for each byte lane toward the array |
| latErr | output | 1 | Latency changed while read words were owed |

## Verification
The assertions assume that READ and WRITE never arrive in the same cycle. They also assume that `casLat` is never zero. The stimulus keeps to both rules: every command is issued alone, and only the codes 1 to 3 are used. Latency changes while a read is in flight are made only on purpose, in the error scenario. That scenario raises no READ during the change, so the latched latency still decides the timing the scoreboard expects.

// File: rtl/casrd_pkg.sv
package casrd_pkg;
  localparam int LAT_W = 2;

  typedef struct packed {
    logic             rdSlot;
    logic             wrSlot;
    logic             flush;
    logic [LAT_W-1:0] lat;
  } pipeCtl_t;
endpackage

// File: rtl/casrd_ctrl.sv
module casrd_ctrl
  import casrd_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdCmd,
  input  logic             wrCmd,
  input  logic [LAT_W-1:0] casLat,
  input  logic [SEL_W-1:0] burstSel,
  input  logic             pipeBusy,
  output pipeCtl_t         ctl,
  output logic             latErr
);
  logic [CNT_W:0]   lenFull;
  logic [CNT_W-1:0] lenM1;
  logic [CNT_W-1:0] rdRem;
  logic [CNT_W-1:0] wrRem;
  logic [LAT_W-1:0] curLat;
  logic             rdBusy;
  logic             wrBusy;

  assign lenFull = (CNT_W+1)'(1) << burstSel;
  assign lenM1   = lenFull[CNT_W-1:0] - CNT_W'(1);
  assign rdBusy  = (rdRem != '0);
  assign wrBusy  = (wrRem != '0);

  always_comb begin
    ctl.flush  = wrCmd;
    ctl.rdSlot = !wrCmd && (rdCmd || rdBusy);
    ctl.wrSlot = !rdCmd && (wrCmd || wrBusy);
    ctl.lat    = curLat;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdRem  <= '0;
      wrRem  <= '0;
      curLat <= LAT_W'(1);
      latErr <= 1'b0;
    end else begin
      latErr <= (rdBusy || pipeBusy) && (casLat != curLat);
      if (wrCmd) begin
        wrRem <= lenM1;
        rdRem <= '0;
      end else if (rdCmd) begin
        rdRem  <= lenM1;
        wrRem  <= '0;
        curLat <= casLat;
      end else begin
        if (rdBusy) rdRem <= rdRem - CNT_W'(1);
        if (wrBusy) wrRem <= wrRem - CNT_W'(1);
      end
    end
  end

  // R8: an error report always follows a cycle with read work outstanding
  assert_err_needs_flight_R8: assert property (@(posedge clk) disable iff (!rstN)
    latErr |-> $past(rdBusy || pipeBusy));

  // R8: the latched latency moves only when a READ is registered
  assert_lat_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!rdCmd || wrCmd) |=> $stable(curLat));
endmodule

// File: rtl/casrd_datapath.sv
module casrd_datapath
  import casrd_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MAX_LAT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  pipeCtl_t          ctl,
  input  logic [DATA_W-1:0] srcData,
  input  logic [DATA_W/8-1:0] dqm,
  output logic [DATA_W-1:0] dqOut,
  output logic [DATA_W/8-1:0] dqOe,
  output logic [DATA_W/8-1:0] wrByteEn,
  output logic              pipeBusy
);
  localparam int LANES = DATA_W / 8;

  logic              stVal  [MAX_LAT];
  logic [DATA_W-1:0] stData [MAX_LAT];
  logic [LANES-1:0]  maskA;
  logic [LANES-1:0]  maskB;
  logic [LAT_W-1:0]  tapIdx;
  logic              tapVal;
  logic [DATA_W-1:0] tapData;

  for (genvar k = 0; k < MAX_LAT; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rstN) begin
          stVal[0]  <= 1'b0;
          stData[0] <= '0;
        end else begin
          stVal[0]  <= ctl.rdSlot;
          stData[0] <= srcData;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rstN) begin
          stVal[k]  <= 1'b0;
          stData[k] <= '0;
        end else begin
          stVal[k]  <= ctl.flush ? 1'b0 : stVal[k-1];
          stData[k] <= stData[k-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskA <= '1;
      maskB <= '1;
    end else begin
      maskA <= dqm;
      maskB <= maskA;
    end
  end

  always_comb begin
    tapIdx = (ctl.lat == '0) ? '0 : ctl.lat - LAT_W'(1);
    tapVal   = 1'b0;
    tapData  = '0;
    pipeBusy = 1'b0;
    for (int k = 0; k < MAX_LAT; k++) begin
      if (k == int'(tapIdx)) begin
        tapVal  = stVal[k];
        tapData = stData[k];
      end
      if (k < int'(tapIdx)) pipeBusy = pipeBusy | stVal[k];
    end
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign dqOe[b]          = tapVal && !maskB[b];
    assign dqOut[b*8 +: 8]  = dqOe[b] ? tapData[b*8 +: 8] : 8'h00;
    assign wrByteEn[b]      = ctl.wrSlot && !dqm[b];

    // R3: a driven lane had its mask low two edges earlier
    assert_rd_mask_delay_R3: assert property (@(posedge clk) disable iff (!rstN)
      dqOe[b] |-> !$past(dqm[b], 2));
  end

  // R6: a registered WRITE leaves every lane released
  assert_flush_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush |=> (dqOe == '0));
endmodule

// File: rtl/casrd_pipe.sv
module casrd_pipe
  import casrd_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MAX_LAT = 3,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdCmd,
  input  logic               wrCmd,
  input  logic [LAT_W-1:0]   casLat,
  input  logic [SEL_W-1:0]   burstSel,
  input  logic [DATA_W/8-1:0] dqm,
  input  logic [DATA_W-1:0]  srcData,
  output logic [DATA_W-1:0]  dqOut,
  output logic [DATA_W/8-1:0] dqOe,
  output logic [DATA_W/8-1:0] wrByteEn,
  output logic               latErr
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  pipeCtl_t ctl;
  logic     pipeBusy;

  casrd_ctrl #(.SEL_W(SEL_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .rdCmd(rdCmd), .wrCmd(wrCmd),
    .casLat(casLat), .burstSel(burstSel), .pipeBusy(pipeBusy),
    .ctl(ctl), .latErr(latErr)
  );

  casrd_datapath #(.DATA_W(DATA_W), .MAX_LAT(MAX_LAT)) data_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .srcData(srcData), .dqm(dqm),
    .dqOut(dqOut), .dqOe(dqOe), .wrByteEn(wrByteEn), .pipeBusy(pipeBusy)
  );

  // R6: commands are issued one at a time
  assert_one_cmd_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(rdCmd && wrCmd));

  // R10: a READ silences the write enables in its own cycle
  assert_rd_cancels_wr_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdCmd && !wrCmd) |-> (wrByteEn == '0));

  // R4: the write mask takes effect with no delay
  assert_wr_nodelay_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrCmd && !rdCmd) |-> (wrByteEn == ~dqm));
endmodule

// File: tb/casrd_pipe_tb_top.sv
module casrd_pipe_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdCmd = 1'b0;
  logic        wrCmd = 1'b0;
  logic [1:0]  casLat = 2'd1;
  logic [1:0]  burstSel = 2'd0;
  logic [1:0]  dqm = 2'b00;
  logic [15:0] srcData = '0;
  logic [15:0] dqOut;
  logic [1:0]  dqOe;
  logic [1:0]  wrByteEn;
  logic        latErr;

  int checks = 0;
  int failures = 0;

  localparam int SLOTS = 512;
  logic        expV [SLOTS];
  logic [15:0] expD [SLOTS];
  logic [1:0]  maskAt [SLOTS];
  int cyc = 0;
  int rdRemB = 0;
  int wrRemB = 0;
  int curLatB = 1;
  logic errExp = 1'b0;

  always #5 clk = ~clk;

  casrd_pipe dut_i (
    .clk(clk), .rstN(rstN), .rdCmd(rdCmd), .wrCmd(wrCmd), .casLat(casLat),
    .burstSel(burstSel), .dqm(dqm), .srcData(srcData), .dqOut(dqOut),
    .dqOe(dqOe), .wrByteEn(wrByteEn), .latErr(latErr)
  );

  function automatic logic [15:0] srcOf(int c);
    return 16'((c * 16'h0137 + 16'h21) ^ 16'hA5C3);
  endfunction

  task automatic checkVal(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
    end
  endtask

  // Driver plus scoreboard: one call is one clock edge.
  task automatic step(string tag, logic rd, logic wr, logic [1:0] lat,
                      logic [1:0] sel, logic [1:0] m);
    int  len;
    logic slot;
    logic busy;
    logic [1:0] weExp;
    logic [1:0] oeExp;
    logic [15:0] outExp;
    rdCmd = rd; wrCmd = wr; casLat = lat; burstSel = sel; dqm = m;
    srcData = srcOf(cyc);
    len = 1 << sel;
    #1;
    weExp = (!rd && (wr || wrRemB > 0)) ? ~m : 2'b00;
    checkVal((rd ? "R10" : "R4"), "wrByteEn", 32'(wrByteEn), 32'(weExp));
    busy = (rdRemB > 0);
    for (int s = cyc; s <= cyc + curLatB - 2; s++) busy = busy | expV[s];
    errExp = busy && (int'(lat) != curLatB);
    slot = 1'b0;
    if (wr) begin
      for (int s = cyc; s < cyc + 4; s++) expV[s] = 1'b0;
      wrRemB = len - 1; rdRemB = 0;
    end else if (rd) begin
      slot = 1'b1; rdRemB = len - 1; wrRemB = 0; curLatB = int'(lat);
    end else begin
      slot = (rdRemB > 0);
      if (rdRemB > 0) rdRemB--;
      if (wrRemB > 0) wrRemB--;
    end
    if (slot) begin
      expV[cyc + curLatB - 1] = 1'b1;
      expD[cyc + curLatB - 1] = srcOf(cyc);
    end
    maskAt[cyc + 1] = m;
    @(posedge clk);
    @(negedge clk);
    oeExp  = expV[cyc] ? ~maskAt[cyc] : 2'b00;
    outExp = {oeExp[1] ? expD[cyc][15:8] : 8'h00, oeExp[0] ? expD[cyc][7:0] : 8'h00};
    checkVal(tag, "dqOe", 32'(dqOe), 32'(oeExp));
    checkVal(tag, "dqOut", 32'(dqOut), 32'(outExp));
    checkVal("R8", "latErr", 32'(latErr), 32'(errExp));
    cyc++;
  endtask

  task automatic idle(string tag, int n, logic [1:0] lat);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 1'b0, lat, 2'd0, 2'b00);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int s = 0; s < SLOTS; s++) begin
      expV[s] = 1'b0; expD[s] = '0; maskAt[s] = 2'b11;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R9: reset state
    checkVal("R9", "dqOe", 32'(dqOe), 32'd0);
    checkVal("R9", "dqOut", 32'(dqOut), 32'd0);
    checkVal("R9", "latErr", 32'(latErr), 32'd0);
    checkVal("R9", "wrByteEn", 32'(wrByteEn), 32'd0);

    // R7: idle drives nothing
    idle("R7", 3, 2'd1);
    // R1: latency 1, single word
    step("R1", 1'b1, 1'b0, 2'd1, 2'd0, 2'b00);
    idle("R1", 3, 2'd1);
    // R2: latency 2, four words
    step("R2", 1'b1, 1'b0, 2'd2, 2'd2, 2'b00);
    idle("R2", 6, 2'd2);
    // R1: latency 3, eight words
    step("R1", 1'b1, 1'b0, 2'd3, 2'd3, 2'b00);
    idle("R1", 11, 2'd3);
    // R3: per-lane masking with a two-clock delay
    step("R3", 1'b1, 1'b0, 2'd2, 2'd3, 2'b00);
    step("R3", 1'b0, 1'b0, 2'd2, 2'd0, 2'b01);
    step("R3", 1'b0, 1'b0, 2'd2, 2'd0, 2'b10);
    step("R3", 1'b0, 1'b0, 2'd2, 2'd0, 2'b11);
    step("R3", 1'b0, 1'b0, 2'd2, 2'd0, 2'b00);
    step("R3", 1'b0, 1'b0, 2'd2, 2'd0, 2'b01);
    idle("R3", 6, 2'd2);
    // R5: truncating READ, no gap
    step("R5", 1'b1, 1'b0, 2'd2, 2'd3, 2'b00);
    idle("R5", 2, 2'd2);
    step("R5", 1'b1, 1'b0, 2'd2, 2'd2, 2'b00);
    idle("R5", 6, 2'd2);
    // R5: back-to-back single-word reads at latency 3
    step("R5", 1'b1, 1'b0, 2'd3, 2'd0, 2'b00);
    step("R5", 1'b1, 1'b0, 2'd3, 2'd0, 2'b00);
    step("R5", 1'b1, 1'b0, 2'd3, 2'd1, 2'b00);
    idle("R5", 5, 2'd3);
    // R6: WRITE cuts a read at latency 3, masks raised beforehand
    step("R6", 1'b1, 1'b0, 2'd3, 2'd3, 2'b00);
    step("R6", 1'b0, 1'b0, 2'd3, 2'd0, 2'b00);
    step("R6", 1'b0, 1'b0, 2'd3, 2'd0, 2'b11);
    step("R6", 1'b0, 1'b0, 2'd3, 2'd0, 2'b11);
    // R4: write burst of four with varying masks
    step("R4", 1'b0, 1'b1, 2'd3, 2'd2, 2'b01);
    step("R4", 1'b0, 1'b0, 2'd3, 2'd0, 2'b10);
    step("R4", 1'b0, 1'b0, 2'd3, 2'd0, 2'b00);
    step("R4", 1'b0, 1'b0, 2'd3, 2'd0, 2'b11);
    idle("R4", 2, 2'd3);
    // R10: READ ends a write burst
    step("R10", 1'b0, 1'b1, 2'd1, 2'd3, 2'b00);
    step("R10", 1'b0, 1'b0, 2'd1, 2'd0, 2'b00);
    step("R10", 1'b1, 1'b0, 2'd1, 2'd1, 2'b00);
    idle("R10", 4, 2'd1);
    // R8: latency input changed mid-burst
    step("R8", 1'b1, 1'b0, 2'd2, 2'd3, 2'b00);
    step("R8", 1'b0, 1'b0, 2'd2, 2'd0, 2'b00);
    step("R8", 1'b0, 1'b0, 2'd3, 2'd0, 2'b00);
    step("R8", 1'b0, 1'b0, 2'd3, 2'd0, 2'b00);
    step("R8", 1'b0, 1'b0, 2'd2, 2'd0, 2'b00);
    idle("R8", 8, 2'd2);
    // R7: back to idle with masks toggling
    step("R7", 1'b0, 1'b0, 2'd2, 2'd0, 2'b11);
    idle("R7", 3, 2'd2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule